// File: doc/BRIEF.md
# Parallel ROM Byte Read Sequencer

This block sits on the host side of an asynchronous 64K x 8 parallel ROM and turns a single-cycle request carrying a 16-bit address into a complete, timing-correct read. It registers the address onto the ROM address pins and pulls chip-enable low. It holds output-enable back until the latest cycle that still meets the address access time. It samples the data byte once the access time has elapsed and returns the byte with a one-cycle valid pulse. It then keeps itself busy until the ROM's outputs have had time to float, so another driver can take the shared data bus safely.

All delays come from a speed-grade parameter and the clock period parameter. Each nanosecond figure becomes a whole number of cycles, always rounded up. Between reads, chip-enable is high and the ROM sits in standby.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While reset is active and after it is released, rom_ce_n and rom_oe_n are 1, and busy and rsp_valid are 0.
- R2: A request (req_valid high while busy is low) is taken at a rising clock edge. At that edge rom_addr takes req_addr, rom_ce_n goes to 0 and busy goes to 1.
- R3: rom_oe_n goes to 0 exactly ACC - OE cycles after the edge where rom_ce_n went to 0. ACC and OE are the access and output-enable cycle counts.
- R4: rsp_valid is a one-cycle pulse that rises exactly ACC cycles after the accepting edge. In that cycle rsp_data equals the rom_data value present just before that edge, and rsp_data holds that value afterwards.
- R5: rom_ce_n and rom_oe_n both return to 1 at the same edge where rsp_valid rises, never earlier.
- R6: After rsp_valid rises, busy stays high for exactly DF cycles, which is the float count. rom_ce_n and rom_oe_n stay high through this interval.
- R7: req_valid has no effect while busy is high. No extra read is started and no extra rsp_valid appears.
- R8: rom_addr does not change while busy is high.
- R9: The speed grades 0, 1, 2 and 3 give access times of 70/90/120/150 ns, output-enable times of 40/50/50/60 ns and float times of 35/40/40/50 ns. ACC, OE and DF are each ceil(ns / CLK_PERIOD_NS).
- R10: rom_oe_n is never 0 while rom_ce_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| req_valid | input | 1 | Read request, taken only when busy is low |
| req_addr | input | 16 | Byte address of the request |
| busy | output | 1 | High from acceptance until the float interval ends |
| rsp_valid | output | 1 | One-cycle pulse marking rsp_data as new |
| rsp_data | output | 8 | Captured byte |
| rom_addr | output | 16 | ROM address pins |
| rom_ce_n | output | 1 | ROM chip-enable, active low |
| rom_oe_n | output | 1 | ROM output-enable, active low |
| rom_data | input | 8 | ROM data pins |

## Verification
The bench builds the block with GRADE = 2 and CLK_PERIOD_NS = 4. This gives 30 access cycles, a 17-cycle output-enable offset and a 10-cycle float guard. The 50 ns output-enable time does not divide evenly by 4 ns, so the rounding-up path decides the offset. The ROM model in the bench returns a corrupted byte until its own elapsed-time counters satisfy the access and output-enable times. Any early capture, or any offset that is one cycle short, therefore shows up as a data mismatch as well as a cycle-count mismatch.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  // R9: per-grade delays in ns
  function automatic int grade_acc_ns(input int g);
    case (g)
      0:       return 70;
      1:       return 90;
      2:       return 120;
      default: return 150;
    endcase
  endfunction

  function automatic int grade_oe_ns(input int g);
    case (g)
      0:       return 40;
      1:       return 50;
      2:       return 50;
      default: return 60;
    endcase
  endfunction

  function automatic int grade_df_ns(input int g);
    case (g)
      0:       return 35;
      1:       return 40;
      2:       return 40;
      default: return 50;
    endcase
  endfunction

  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

endpackage

// File: rtl/prom_rd_timer.sv
module prom_rd_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || en)  cnt <= cnt_d;
  end

endmodule

// File: rtl/prom_rd_hold.sv
module prom_rd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

endmodule

// File: rtl/prom_rd_seq.sv
module prom_rd_seq
  import prom_rd_pkg::*;
#(
  parameter int ACC_CYC = 30,
  parameter int OE_OFF  = 17,
  parameter int DF_CYC  = 10,
  parameter int CW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_en,
  output logic          addr_ld,
  output logic          cap_ld,
  output logic          ce_n,
  output logic          oe_n,
  output logic          rsp_valid,
  output logic          busy
);

  localparam logic [CW-1:0] ACC_LAST = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] DF_LAST  = CW'(DF_CYC - 1);
  localparam bit            OE_AT_CE = (OE_OFF == 0);
  localparam logic [CW-1:0] OE_LAST  = OE_AT_CE ? '0 : CW'(OE_OFF - 1);

  rd_state_e st_q, st_d;
  logic      ce_n_d, oe_n_d, rsp_valid_d;
  logic      accept, hit_oe, hit_cap, hit_end;

  always_comb begin
    accept  = (st_q == ST_IDLE) && req_valid;
    hit_oe  = (st_q == ST_ACCESS) && !OE_AT_CE && (cnt == OE_LAST);
    hit_cap = (st_q == ST_ACCESS) && (cnt == ACC_LAST);
    hit_end = (st_q == ST_FLOAT) && (cnt == DF_LAST);
  end

  always_comb begin
    st_d        = st_q;
    ce_n_d      = ce_n;
    oe_n_d      = oe_n;
    rsp_valid_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_ACCESS;
          ce_n_d = 1'b0;
          if (OE_AT_CE) oe_n_d = 1'b0;
        end
      end
      ST_ACCESS: begin
        if (hit_cap) begin
          st_d        = ST_FLOAT;
          ce_n_d      = 1'b1;
          oe_n_d      = 1'b1;
          rsp_valid_d = 1'b1;
        end else if (hit_oe) begin
          oe_n_d = 1'b0;
        end
      end
      ST_FLOAT: begin
        if (hit_end) st_d = ST_IDLE;
      end
      default: begin
        st_d   = ST_IDLE;
        ce_n_d = 1'b1;
        oe_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      rsp_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      ce_n      <= ce_n_d;
      oe_n      <= oe_n_d;
      rsp_valid <= rsp_valid_d;
    end
  end

  assign cnt_clr = accept || hit_cap;
  assign cnt_en  = (st_q != ST_IDLE);
  assign addr_ld = accept;
  assign cap_ld  = hit_cap;
  assign busy    = (st_q != ST_IDLE);

  // R10: output-enable only together with chip-enable
  a_r10_oe_within_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ce_n);

  // R4: response is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5: controls released in the capture cycle
  a_r5_release_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ce_n && oe_n));

  // R6: during the float guard the ROM stays deselected
  a_r6_float_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLOAT) |-> (ce_n && oe_n && busy));

  // R2: chip-enable falls only on an accepted request
  a_r2_ce_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> $past(req_valid));

  // R6: a float interval never runs past its count
  a_r6_float_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLOAT) |-> (cnt <= DF_LAST));

endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_rd_pkg::*;
#(
  parameter int GRADE         = 0,
  parameter int CLK_PERIOD_NS = 4,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_data
);

  // R9: delays in whole cycles, rounded up
  localparam int ACC_CYC = ns_to_cyc(grade_acc_ns(GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC  = ns_to_cyc(grade_oe_ns(GRADE),  CLK_PERIOD_NS);
  localparam int DF_CYC  = ns_to_cyc(grade_df_ns(GRADE),  CLK_PERIOD_NS);
  localparam int OE_OFF  = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 0;
  localparam int MAX_CYC = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [1:0]    rst_pipe;
  logic          rst_n_int;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en, addr_ld, cap_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  prom_rd_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  prom_rd_seq #(
    .ACC_CYC (ACC_CYC),
    .OE_OFF  (OE_OFF),
    .DF_CYC  (DF_CYC),
    .CW      (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .cnt       (cnt),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .addr_ld   (addr_ld),
    .cap_ld    (cap_ld),
    .ce_n      (rom_ce_n),
    .oe_n      (rom_oe_n),
    .rsp_valid (rsp_valid),
    .busy      (busy)
  );

  prom_rd_hold #(.W(ADDR_W)) u_addr_reg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ld    (addr_ld),
    .d     (req_addr),
    .q     (rom_addr)
  );

  prom_rd_hold #(.W(DATA_W)) u_data_reg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ld    (cap_ld),
    .d     (rom_data),
    .q     (rsp_data)
  );

  // R8: address pins frozen while a read or its float guard runs
  a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy |=> $stable(rom_addr));

  // R4: captured byte holds between responses
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rsp_valid |=> (rsp_valid || $stable(rsp_data)));

endmodule

// File: tb/prom_rd_ctrl_tb.sv
module prom_rd_ctrl_tb;

  localparam int GRADE = 2;
  localparam int PER   = 4;

  function automatic int tb_ceil(input int ns);
    return (ns + PER - 1) / PER;
  endfunction

  // R9: independent timing table for grade 2
  localparam int T_ACC = 120;
  localparam int T_OE  = 50;
  localparam int T_DF  = 40;
  localparam int ACC   = (T_ACC + PER - 1) / PER;
  localparam int OEC   = (T_OE + PER - 1) / PER;
  localparam int DF    = (T_DF + PER - 1) / PER;
  localparam int OFF   = ACC - OEC;

  logic        clk, rst_n, req_valid, busy, rsp_valid, rom_ce_n, rom_oe_n;
  logic [15:0] req_addr, rom_addr;
  logic [7:0]  rsp_data, rom_data;

  int checks, fails;
  bit done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  prom_rd_ctrl #(.GRADE(GRADE), .CLK_PERIOD_NS(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_data(rom_data)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // ROM model: wrong byte until its own elapsed times are met
  int ce_age, oe_age, addr_age;
  logic [15:0] addr_prev;
  always @(posedge clk) begin
    ce_age    <= rom_ce_n ? 0 : ce_age + 1;
    oe_age    <= rom_oe_n ? 0 : oe_age + 1;
    addr_age  <= (rom_addr != addr_prev) ? 1 : addr_age + 1;
    addr_prev <= rom_addr;
  end
  always_comb begin
    if (!rom_ce_n && !rom_oe_n && (ce_age + 1) * PER >= T_ACC &&
        (oe_age + 1) * PER >= T_OE && (addr_age + 1) * PER >= T_ACC)
      rom_data = rom_byte(rom_addr);
    else
      rom_data = ~rom_byte(rom_addr);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard queue of accepted addresses
  logic [15:0] exp_q[$];

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    exp_q.push_back(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  bit prev_ce_n, prev_oe_n, in_rd, in_fl;
  int k, fl, nrsp;
  logic [15:0] cur_a;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!rom_ce_n && prev_ce_n) begin
        k = 0;
        in_rd = 1;
        if (exp_q.size() == 0) begin
          chk(0, "R7 read started without request", 1, 0);
          cur_a = rom_addr;
        end else begin
          cur_a = exp_q.pop_front();
          chk(rom_addr == cur_a, "R2 address driven", rom_addr, cur_a);
          chk(busy, "R2 busy on accept", busy, 1);
        end
      end else if (in_rd) k++;
      if (!rom_oe_n && prev_oe_n)
        chk(k == OFF, "R3 oe offset", k, OFF);
      if (rsp_valid) begin
        nrsp++;
        chk(in_rd, "R4 stray response", 0, 1);
        chk(k == ACC, "R4 capture cycle", k, ACC);
        chk(rsp_data == rom_byte(cur_a), "R4 data", rsp_data, rom_byte(cur_a));
        chk(rom_ce_n && rom_oe_n, "R5 release at capture", {rom_ce_n, rom_oe_n}, 3);
        in_rd = 0;
        in_fl = 1;
        fl = 0;
      end else if (in_fl) begin
        fl++;
        if (!busy) begin
          chk(fl == DF, "R6 float guard length", fl, DF);
          in_fl = 0;
        end else
          chk(rom_ce_n && rom_oe_n, "R6 deselected in float", {rom_ce_n, rom_oe_n}, 3);
      end
      prev_ce_n = rom_ce_n;
      prev_oe_n = rom_oe_n;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0; nrsp = 0;
    prev_ce_n = 1; prev_oe_n = 1; in_rd = 0; in_fl = 0;
    req_valid = 1'b0; req_addr = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rom_ce_n && rom_oe_n, "R1 controls high in reset", {rom_ce_n, rom_oe_n}, 3);
    chk(!busy && !rsp_valid, "R1 idle in reset", {busy, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rom_ce_n && rom_oe_n, "R1 controls high after reset", {rom_ce_n, rom_oe_n}, 3);
    chk(!busy, "R1 not busy after reset", busy, 0);
    // R9 rounding: 50 ns at 4 ns must give 13 cycles
    chk(tb_ceil(T_OE) == 13 && OFF == 17, "R9 rounded offset", OFF, 17);

    do_read(16'h0000);
    do_read(16'hFFFF);
    do_read(16'h1234);
    do_read(16'hA5A5);

    // R7: requests during busy are ignored
    do_read(16'h0F0F);
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_addr = 16'hDEAD;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (40) begin
      @(negedge clk);
      chk(rom_ce_n && !rsp_valid, "R7 no extra read", {rom_ce_n, rsp_valid}, 2);
    end

    // back-to-back reads
    for (int i = 0; i < 4; i++) do_read(16'(16'h8001 + i * 16'h0111));
    while (busy || in_fl) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(nrsp == 9, "R4 response count", nrsp, 9);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule